// File: doc/BRIEF.md
# Magic Read-Address Command Detector

This block sits beside an SRAM access bus and watches for a fixed chain of read accesses. Five reads to fixed addresses, in a set order, arm the chain. A sixth read then picks the command. One final address starts a store and the other starts a recall. The block reports the command as a one-cycle start pulse. It then raises a chip-disable that blocks the memory until the operation is done. Any write, or any read that breaks the order, throws the chain away and no command is issued. The engine that runs the store or recall is outside this block. Its busy signal comes back in and gates the detector.

Accesses are counted on falling edges of a per-access strobe, sampled in the `clk` domain. An access is counted only while chip select is low. Output enable has no influence, so reads qualified by chip select alone are accepted.

The controller has eight states. ST_IDLE is step 0. ST_K1 to ST_K5 mean one to five chain addresses have been matched. ST_ARMED means a command was launched and the busy input has not yet risen. ST_ACTIVE means the busy input is high.

The transitions are:
- ADVANCE: a matching read moves ST_Kn to ST_Kn+1.
- RESTART: a non-matching read equal to the first chain address goes to ST_K1.
- ABORT: a write or any other non-matching read goes to ST_IDLE.
- LAUNCH: a final-address read in ST_K5 goes to ST_ARMED and emits a pulse.
- ENGAGE: busy high in ST_ARMED goes to ST_ACTIVE.
- RELEASE: busy low in ST_ACTIVE goes to ST_IDLE.
- HOLD: busy high in any hunting state forces ST_IDLE.

Top module: `magicseq_detector`

## Requirements
- R1: Reads at 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F, in that order, followed by a read at 0x8FC0, make `store_go` high for exactly one cycle. That cycle is the one after the clock edge at which the last strobe fall is sampled.
- R2: The same five reads followed by a read at 0x4C63 make `recall_go` high for one cycle, with the same timing as R1.
- R3: An access is a cycle in which `acc_strobe` was 1 at the previous clock edge and is 0 now. The access counts only if `cs_n` is 0. Strobe falls with `cs_n` at 1 leave the chain position unchanged.
- R4: The level of `oe_n` has no effect on whether a read advances the chain or launches a command.
- R5: An access with `we_n` at 0 returns the chain to step 0, even if its address is a chain address.
- R6: A read that does not match the expected address aborts the chain. It restarts at step 1 if it equals 0x4E38, and otherwise at step 0. This includes a wrong sixth address.
- R7: `store_go` and `recall_go` are never high together, and each stays high for a single cycle.
- R8: `chip_off` rises together with a start pulse. It stays high while waiting for `op_busy` and while `op_busy` is high. It falls one cycle after `op_busy` is sampled low again. Accesses made while `chip_off` is high are ignored, and the chain starts from step 0 afterwards.
- R9: While `chip_off` is low, `op_busy` high returns the chain to step 0 and suppresses any launch in that cycle.
- R10: After reset, `store_go`, `recall_go` and `chip_off` are 0 and the chain is at step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (16) | Access address |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low (ignored) |
| we_n | input | 1 | Write enable, active low |
| acc_strobe | input | 1 | Per-access strobe; a falling edge marks one access |
| op_busy | input | 1 | High while the store/recall engine runs |
| store_go | output | 1 | One-cycle store start pulse |
| recall_go | output | 1 | One-cycle recall start pulse |
| chip_off | output | 1 | Memory disabled while a launched command is pending or running |

## Verification
Two events can land in one cycle: the final chain read, which would LAUNCH, and `op_busy` rising while the detector is still hunting, which would HOLD. The bench provokes this by bringing the chain to step 5 and raising `op_busy` at the same edge where the last strobe fall is sampled. It expects HOLD to win: no pulse, `chip_off` stays low, and a later complete chain is needed to launch. Random runs also mix in busy pulses and deselected strobes, and a bench-side step model predicts every outcome.

// File: rtl/magicseq_pkg.sv
package magicseq_pkg;

    localparam int CHAIN_LEN = 5;
    localparam int KEY_W     = 16;

    localparam logic [KEY_W-1:0] STORE_KEY  = 16'h8FC0;
    localparam logic [KEY_W-1:0] RECALL_KEY = 16'h4C63;

    // Ordered chain: the index is the step at which the address is expected.
    function automatic logic [KEY_W-1:0] chain_key(input int idx);
        logic [KEY_W-1:0] k;
        case (idx)
            0:       k = 16'h4E38;
            1:       k = 16'hB1C7;
            2:       k = 16'h83E0;
            3:       k = 16'h7C1F;
            4:       k = 16'h703F;
            default: k = '0;
        endcase
        return k;
    endfunction

    // Hunting states are encoded as their step number (0..5).
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_K1     = 3'd1,
        ST_K2     = 3'd2,
        ST_K3     = 3'd3,
        ST_K4     = 3'd4,
        ST_K5     = 3'd5,
        ST_ARMED  = 3'd6,
        ST_ACTIVE = 3'd7
    } seq_state_t;

endpackage

// File: rtl/magicseq_edge.sv
module magicseq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic fall
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level;
        end
    end

    assign fall = level_q & ~level;

endmodule

// File: rtl/magicseq_match.sv
module magicseq_match
    import magicseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [CHAIN_LEN-1:0] hit_chain,
    output logic                 hit_store,
    output logic                 hit_recall
);
    generate
        for (genvar k = 0; k < CHAIN_LEN; k++) begin : g_key
            assign hit_chain[k] = (addr == ADDR_W'(chain_key(k)));
        end
    endgenerate

    assign hit_store  = (addr == ADDR_W'(STORE_KEY));
    assign hit_recall = (addr == ADDR_W'(RECALL_KEY));

endmodule

// File: rtl/magicseq_fsm.sv
module magicseq_fsm
    import magicseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fire,
    input  logic                 is_write,
    input  logic                 op_busy,
    input  logic [CHAIN_LEN-1:0] hit_chain,
    input  logic                 hit_store,
    input  logic                 hit_recall,
    output logic                 store_go,
    output logic                 recall_go,
    output logic                 chip_off,
    output logic [2:0]           fsm_pos
);
    seq_state_t state, nxt;
    logic       step_hit;
    logic       launch_st, launch_rc;

    // Does the current address match the one expected at this step?
    always_comb begin
        step_hit = 1'b0;
        for (int k = 0; k < CHAIN_LEN; k++) begin
            if (int'(state) == k) begin
                step_hit = hit_chain[k];
            end
        end
    end

    always_comb begin
        nxt       = state;
        launch_st = 1'b0;
        launch_rc = 1'b0;
        unique case (state)
            ST_IDLE, ST_K1, ST_K2, ST_K3, ST_K4, ST_K5: begin
                if (op_busy) begin
                    nxt = ST_IDLE;                      // HOLD
                end else if (fire) begin
                    if (is_write) begin
                        nxt = ST_IDLE;                  // ABORT on write
                    end else if (state == ST_K5 && hit_store) begin
                        nxt       = ST_ARMED;           // LAUNCH store
                        launch_st = 1'b1;
                    end else if (state == ST_K5 && hit_recall) begin
                        nxt       = ST_ARMED;           // LAUNCH recall
                        launch_rc = 1'b1;
                    end else if (state != ST_K5 && step_hit) begin
                        nxt = seq_state_t'(state + 3'd1);   // ADVANCE
                    end else if (hit_chain[0]) begin
                        nxt = ST_K1;                    // RESTART
                    end else begin
                        nxt = ST_IDLE;                  // ABORT
                    end
                end
            end
            ST_ARMED: begin
                if (op_busy) begin
                    nxt = ST_ACTIVE;                    // ENGAGE
                end
            end
            ST_ACTIVE: begin
                if (!op_busy) begin
                    nxt = ST_IDLE;                      // RELEASE
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_go  <= 1'b0;
            recall_go <= 1'b0;
            chip_off  <= 1'b0;
        end else begin
            store_go  <= launch_st;
            recall_go <= launch_rc;
            chip_off  <= (nxt == ST_ARMED) || (nxt == ST_ACTIVE);
        end
    end

    assign fsm_pos = state;

    // Entry into ST_ARMED only happens from the last chain step.
    assert_armed_from_k5_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && $past(state) != ST_ARMED) |-> $past(state) == ST_K5);

    // A write never advances the chain.
    assert_write_no_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && is_write && state != ST_ARMED && state != ST_ACTIVE) |=> state == ST_IDLE);

    // Busy in a hunting state drops the step to zero.
    assert_busy_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_busy && !chip_off) |=> (state == ST_IDLE || state == ST_ACTIVE));

endmodule

// File: rtl/magicseq_detector.sv
module magicseq_detector
    import magicseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              acc_strobe,
    input  logic              op_busy,
    output logic              store_go,
    output logic              recall_go,
    output logic              chip_off
);
    logic                 strobe_fall;
    logic                 fire;
    logic [CHAIN_LEN-1:0] hit_chain;
    logic                 hit_store, hit_recall;
    logic [2:0]           fsm_pos;

    magicseq_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (acc_strobe),
        .fall  (strobe_fall)
    );

    magicseq_match #(.ADDR_W(ADDR_W)) u_match (
        .addr       (bus_addr),
        .hit_chain  (hit_chain),
        .hit_store  (hit_store),
        .hit_recall (hit_recall)
    );

    // Chip select alone qualifies an access; output enable plays no part.
    assign fire = strobe_fall & ~cs_n;

    magicseq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .is_write   (~we_n),
        .op_busy    (op_busy),
        .hit_chain  (hit_chain),
        .hit_store  (hit_store),
        .hit_recall (hit_recall),
        .store_go   (store_go),
        .recall_go  (recall_go),
        .chip_off   (chip_off),
        .fsm_pos    (fsm_pos)
    );

    assert_pulse_mutex_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_go && recall_go));

    assert_store_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        store_go |=> !store_go);

    assert_recall_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        recall_go |=> !recall_go);

    assert_pulse_disables_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (store_go || recall_go) |-> $rose(chip_off));

    assert_write_no_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_fall && !cs_n && !we_n) |=> !(store_go || recall_go));

    assert_busy_no_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_busy && !chip_off) |=> !(store_go || recall_go));

    assert_deselect_no_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_fall && cs_n) |=> !(store_go || recall_go));

    assert_oe_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && we_n && oe_n && !op_busy && fsm_pos == 3'd5 && hit_store) |=> store_go);

    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_off && $past(chip_off)) |-> !(store_go || recall_go));

endmodule

// File: tb/magicseq_detector_test.sv
`timescale 1ns/1ps
module magicseq_detector_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic        acc_strobe = 1'b0, op_busy = 1'b0;
    logic        store_go, recall_go, chip_off;

    int n_run = 0, n_fail = 0;
    int m_step = 0;
    bit m_wait = 0;
    bit done = 0;

    always #5 clk = ~clk;

    magicseq_detector #(.ADDR_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .cs_n(cs_n),
        .oe_n(oe_n), .we_n(we_n), .acc_strobe(acc_strobe), .op_busy(op_busy),
        .store_go(store_go), .recall_go(recall_go), .chip_off(chip_off)
    );

    function automatic logic [15:0] key_of(input int k);
        logic [15:0] v;
        case (k)
            0: v = 16'h4E38;
            1: v = 16'hB1C7;
            2: v = 16'h83E0;
            3: v = 16'h7C1F;
            4: v = 16'h703F;
            default: v = 16'h0000;
        endcase
        return v;
    endfunction

    localparam logic [15:0] K_STORE  = 16'h8FC0;
    localparam logic [15:0] K_RECALL = 16'h4C63;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One access: strobe high for a cycle, then low; outputs checked after the fall edge.
    task automatic access(input logic [15:0] a, input bit cs, input bit oe, input bit we,
                          input bit busy_fall, input string req);
        bit es, er;
        @(negedge clk);
        bus_addr = a; cs_n = cs; oe_n = oe; we_n = we; acc_strobe = 1'b1;
        @(negedge clk);
        acc_strobe = 1'b0;
        if (busy_fall) op_busy = 1'b1;
        @(negedge clk);
        es = 0; er = 0;
        if (m_wait) begin
        end else if (busy_fall) begin
            m_step = 0;
        end else if (!cs) begin
            if (!we) m_step = 0;
            else if (m_step == 5 && a == K_STORE) begin es = 1; m_wait = 1; end
            else if (m_step == 5 && a == K_RECALL) begin er = 1; m_wait = 1; end
            else if (m_step < 5 && a == key_of(m_step)) m_step++;
            else if (a == key_of(0)) m_step = 1;
            else m_step = 0;
        end
        check(store_go == es,  {req, " store_go"},  int'(store_go),  int'(es));
        check(recall_go == er, {req, " recall_go"}, int'(recall_go), int'(er));
        check(chip_off == m_wait, {req, " chip_off"}, int'(chip_off), int'(m_wait));
        if (busy_fall) op_busy = 1'b0;
        if (es || er) begin
            @(negedge clk);
            check(!store_go && !recall_go, "R7 pulse width", int'(store_go | recall_go), 0);
            check(chip_off, "R8 chip_off held", int'(chip_off), 1);
        end
    endtask

    // Ignored access while disabled, busy handshake, release.
    task automatic finish_op(input int hold);
        access(key_of(0), 0, 0, 1, 0, "R8 access while armed");
        @(negedge clk);
        op_busy = 1'b1;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(chip_off, "R8 chip_off during busy", int'(chip_off), 1);
        end
        access(K_STORE, 0, 1, 1, 0, "R8 access while busy");
        op_busy = 1'b0;
        @(negedge clk);
        m_wait = 0; m_step = 0;
        check(!chip_off, "R8 chip_off release", int'(chip_off), 0);
    endtask

    task automatic run_prefix(input bit oe);
        for (int k = 0; k < 5; k++) access(key_of(k), 0, oe, 1, 0, "R1 chain step");
    endtask

    initial begin : watchdog
        #1500000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int r;
        logic [15:0] a;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(!store_go && !recall_go && !chip_off, "R10 reset outputs",
              int'({store_go, recall_go, chip_off}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!store_go && !recall_go && !chip_off, "R10 after release",
              int'({store_go, recall_go, chip_off}), 0);

        // R1 store, oe_n high (R4)
        run_prefix(1);
        access(K_STORE, 0, 1, 1, 0, "R1 store launch oe high R4");
        finish_op(3);

        // R2 recall, oe_n low
        run_prefix(0);
        access(K_RECALL, 0, 0, 1, 0, "R2 recall launch");
        finish_op(1);

        // R3 deselected strobes are invisible
        for (int k = 0; k < 5; k++) begin
            access(16'h1111, 1, 0, 0, 0, "R3 deselected write");
            access(key_of(k), 0, 1, 1, 0, "R3 chain step");
        end
        access(16'h2222, 1, 1, 1, 0, "R3 deselected read");
        access(K_STORE, 0, 1, 1, 0, "R3 store after deselects");
        finish_op(2);

        // R5 write to a chain address aborts
        access(key_of(0), 0, 1, 1, 0, "R5 step");
        access(key_of(1), 0, 1, 1, 0, "R5 step");
        access(key_of(2), 0, 1, 0, 0, "R5 write at chain addr");
        access(key_of(2), 0, 1, 1, 0, "R5 after abort");
        access(key_of(3), 0, 1, 1, 0, "R5 after abort");
        access(key_of(4), 0, 1, 1, 0, "R5 after abort");
        access(K_STORE, 0, 1, 1, 0, "R5 no launch");
        access(key_of(0), 0, 1, 0, 0, "R5 write first key");
        access(key_of(1), 0, 1, 1, 0, "R5 not restarted");

        // R6 restart at first address
        access(key_of(0), 0, 1, 1, 0, "R6 step");
        access(key_of(1), 0, 1, 1, 0, "R6 step");
        access(key_of(0), 0, 1, 1, 0, "R6 restart");
        for (int k = 1; k < 5; k++) access(key_of(k), 0, 1, 1, 0, "R6 resumed");
        access(K_STORE, 0, 1, 1, 0, "R6 store after restart");
        finish_op(1);

        // R6 wrong sixth address
        run_prefix(1);
        access(16'h1234, 0, 1, 1, 0, "R6 wrong final");
        access(K_RECALL, 0, 1, 1, 0, "R6 no late launch");

        // R9 busy mid-chain
        run_prefix(1);
        @(negedge clk); op_busy = 1'b1;
        @(negedge clk); op_busy = 1'b0; m_step = 0;
        access(K_STORE, 0, 1, 1, 0, "R9 busy cleared chain");

        // R9 busy rising on the same edge as the final read
        run_prefix(1);
        access(K_STORE, 0, 1, 1, 1, "R9 busy same cycle as launch");
        access(K_STORE, 0, 1, 1, 0, "R9 no launch after collision");
        run_prefix(0);
        access(K_RECALL, 0, 1, 1, 0, "R2 recall after collision");
        finish_op(2);

        // Random mix
        for (int it = 0; it < 400; it++) begin
            r = $urandom_range(99);
            if (r < 55) a = (m_step < 5) ? key_of(m_step) : (($urandom_range(1) == 1) ? K_STORE : K_RECALL);
            else if (r < 70) a = key_of(0);
            else if (r < 80) a = key_of($urandom_range(4));
            else a = 16'($urandom);
            if ($urandom_range(19) == 0) begin
                @(negedge clk); op_busy = 1'b1;
                @(negedge clk); op_busy = 1'b0; m_step = 0;
            end
            access(a, ($urandom_range(9) == 0), $urandom_range(1) == 1,
                   !($urandom_range(11) == 0), ($urandom_range(29) == 0), "R6 random mix");
            if (m_wait) finish_op($urandom_range(1, 4));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule